// File: doc/BRIEF.md
# Real-Time Clock Half-Minute Adjust Controller

This block holds the control bits of a real-time clock: a half-minute adjust bit, a prescaler stop bit and a bank-select bit. Setting the adjust bit starts an adjustment. The adjustment is timed in ticks of the 32.768 kHz time base. For its first part, the block fences host access to the bank-0 timekeeping registers. When that fence lifts, it sends one strobe to the external seconds/minutes chain. That chain clears the seconds when they are below 30 and carries into the minutes otherwise. A few ticks later the adjust bit drops to 0 by itself.

The host reaches the block through a 4-bit register port. Reads of timekeeping registers come back from the register file through `tk_rdata`. The controller either passes them on or forces them to zero. A write to a timekeeping register leaves on `wr_fwd` only when the fence allows it. An adjustment can also be requested by a rising edge on a hardware pin. Each adjustment raises a one-cycle pulse that sets the read flag held in another control register. Data protection freezes the stop and adjust bits but leaves bank selection writable.

Top module: `rtc_adj_ctrl`

## Requirements
- R1: A write to address 0xD with data bit 0 set, while `protect` is 0 and no adjustment is running, sets the adjust bit on the next clock edge. Writing bit 0 as 0 leaves the adjust bit unchanged.
- R2: From the edge that sets the adjust bit until the 5th tick after it, host access to bank-0 addresses 0x0 to 0xC is fenced. `blk_map` carries one bit per address.
- R3: While `cal_mode` is 0, addresses 0x6 to 0xB stay open during the fence. While `cal_mode` is 1, all of 0x0 to 0xC are fenced.
- R4: A fenced read returns 0x0 on `rdata`, and a fenced write does not raise `wr_fwd`. Nothing is fenced while bank 1 is selected.
- R5: The adjust bit clears on the edge that consumes the 8th tick after it was set.
- R6: A rising edge on `hw_adj_req` starts an adjustment with the same fence, strobe and self-clear as R1, regardless of `protect`.
- R7: `flag_set` is high for exactly the one cycle after each edge that sets the adjust bit.
- R8: `adj_strobe` is high for exactly one cycle, the cycle after the edge that consumes the 5th tick.
- R9: An adjust request from either source while the adjust bit is 1 is ignored and does not restart the timing.
- R10: Bit 1 of address 0xD is the stop bit. `presc_halt` equals it, and `ctrl_q` bit 1 reads it.
- R11: While `protect` is 1, a write to 0xD changes only the bank bit (bit 2). The stop and adjust bits keep their values.
- R12: A read of 0xD returns {0, bank, stop, adjust} and is never fenced. `rdata` is 0x0 whenever `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per 32.768 kHz period |
| hw_adj_req | input | 1 | Hardware adjust request, acted on at rising edge |
| cal_mode | input | 1 | 1: calendar registers in use; 0: 0x6..0xB are RAM |
| protect | input | 1 | Data-protect mode |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 4 | Host register address |
| wdata | input | 4 | Host write data |
| tk_rdata | input | 4 | Read data from the timekeeping register file |
| rdata | output | 4 | Host read data |
| wr_fwd | output | 1 | Write passed on to the timekeeping register file |
| blk_map | output | 16 | Fenced flag for each address |
| ctrl_q | output | 4 | Control bits {0, bank, stop, adjust} |
| flag_set | output | 1 | One-cycle read-flag set pulse |
| adj_strobe | output | 1 | One-cycle half-minute adjust strobe to the counter chain |
| presc_halt | output | 1 | Hold the prescaler stages at 4096 Hz and below |

## Verification
The fence map, `rdata` and `wr_fwd` respond in the same cycle as the address. The bench checks them after the inputs settle and before the clock edge. Control bits, `presc_halt` and `flag_set` change one edge after the write or request. `adj_strobe` comes one edge after the 5th tick, and the adjust bit falls on the edge of the 8th tick. These are checked at the falling edge that follows. A reference model in the bench counts ticks since each start, so every expected value comes from the requirement's own cycle count.

// File: rtl/rtc_adj_pkg.sv
package rtc_adj_pkg;
   // Bit positions inside the control register
   localparam int unsigned BIT_ADJ  = 0;
   localparam int unsigned BIT_HALT = 1;
   localparam int unsigned BIT_BANK = 2;

   // Fenced window inside bank 0 and its RAM exception
   localparam int unsigned FENCE_LO = 0;
   localparam int unsigned FENCE_HI = 12;
   localparam int unsigned RAM_LO   = 6;
   localparam int unsigned RAM_HI   = 11;
   localparam int unsigned CTRL_AD  = 13;

   function automatic logic in_fence(input int unsigned a, input logic cal);
      logic hit;
      hit = (a >= FENCE_LO) && (a <= FENCE_HI);
      if (!cal && (a >= RAM_LO) && (a <= RAM_HI)) hit = 1'b0;
      return hit;
   endfunction
endpackage

// File: rtl/rtc_adj_timer.sv
module rtc_adj_timer #(
   parameter int unsigned LOCK_TICKS  = 5,
   parameter int unsigned CLEAR_TICKS = 8,
   parameter bit          HW_EDGE     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic hw_req,
   input  logic sw_start,
   output logic adj_q,
   output logic lock_active,
   output logic adj_strobe,
   output logic flag_set
);
   localparam int unsigned CW = $clog2(CLEAR_TICKS + 1);

   logic [CW-1:0] cnt;
   logic          hw_go;
   logic          start;

   generate
      if (HW_EDGE) begin : g_edge
         logic prev;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev <= 1'b0;
            else        prev <= hw_req;
         end
         assign hw_go = hw_req & ~prev;
      end else begin : g_level
         assign hw_go = hw_req;
      end
   endgenerate

   assign start       = (hw_go | sw_start) & ~adj_q;
   assign lock_active = adj_q && (cnt < CW'(LOCK_TICKS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adj_q      <= 1'b0;
         cnt        <= '0;
         adj_strobe <= 1'b0;
         flag_set   <= 1'b0;
      end else begin
         flag_set   <= start;
         adj_strobe <= adj_q & tick & (cnt == CW'(LOCK_TICKS - 1));
         if (start) begin
            adj_q <= 1'b1;
            cnt   <= '0;
         end else if (adj_q && tick) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(CLEAR_TICKS - 1)) adj_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rtc_adj_ctrlreg.sv
module rtc_adj_ctrlreg #(
   parameter int unsigned AW = 4,
   parameter int unsigned DW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          protect,
   input  logic          adj_q,
   output logic          sw_start,
   output logic          halt_q,
   output logic          bank_q,
   output logic [DW-1:0] ctrl_word
);
   import rtc_adj_pkg::*;

   logic hit;
   assign hit      = wr_en && (addr == AW'(CTRL_AD));
   assign sw_start = hit && !protect && wdata[BIT_ADJ];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b0;
         bank_q <= 1'b0;
      end else if (hit) begin
         bank_q <= wdata[BIT_BANK];
         if (!protect) halt_q <= wdata[BIT_HALT];
      end
   end

   always_comb begin
      ctrl_word           = '0;
      ctrl_word[BIT_ADJ]  = adj_q;
      ctrl_word[BIT_HALT] = halt_q;
      ctrl_word[BIT_BANK] = bank_q;
   end
endmodule

// File: rtl/rtc_adj_gate.sv
module rtc_adj_gate #(
   parameter int unsigned AW = 4,
   parameter int unsigned DW = 4
) (
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [AW-1:0]    addr,
   input  logic             cal_mode,
   input  logic             bank_q,
   input  logic             lock_active,
   input  logic [DW-1:0]    ctrl_word,
   input  logic [DW-1:0]    tk_rdata,
   output logic [DW-1:0]    rdata,
   output logic             wr_fwd,
   output logic [2**AW-1:0] blk_map
);
   import rtc_adj_pkg::*;
   localparam int unsigned NA = 2 ** AW;

   logic ctrl_hit;
   assign ctrl_hit = (addr == AW'(CTRL_AD));

   genvar a;
   generate
      for (a = 0; a < NA; a++) begin : g_map
         assign blk_map[a] = lock_active && !bank_q && in_fence(a, cal_mode);
      end
   endgenerate

   assign wr_fwd = wr_en && !ctrl_hit && !blk_map[addr];

   always_comb begin
      if (!rd_en || blk_map[addr]) rdata = '0;
      else if (ctrl_hit)           rdata = ctrl_word;
      else                         rdata = tk_rdata;
   end
endmodule

// File: rtl/rtc_adj_ctrl.sv
module rtc_adj_ctrl #(
   parameter int unsigned AW          = 4,
   parameter int unsigned DW          = 4,
   parameter int unsigned LOCK_TICKS  = 5,
   parameter int unsigned CLEAR_TICKS = 8,
   parameter bit          HW_EDGE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              hw_adj_req,
   input  logic              cal_mode,
   input  logic              protect,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [3:0]        addr,
   input  logic [3:0]        wdata,
   input  logic [3:0]        tk_rdata,
   output logic [3:0]        rdata,
   output logic              wr_fwd,
   output logic [15:0]       blk_map,
   output logic [3:0]        ctrl_q,
   output logic              flag_set,
   output logic              adj_strobe,
   output logic              presc_halt
);
   generate
      if (AW != 4 || DW != 4) begin : g_bad_width
         $error("rtc_adj_ctrl: port widths fixed at 4");
      end
      if (LOCK_TICKS == 0 || LOCK_TICKS >= CLEAR_TICKS) begin : g_bad_ticks
         $error("rtc_adj_ctrl: need 0 < LOCK_TICKS < CLEAR_TICKS");
      end
   endgenerate

   logic adj_q, lock_active, sw_start, halt_q, bank_q;
   logic [DW-1:0] ctrl_word;

   rtc_adj_ctrlreg #(.AW(AW), .DW(DW)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .protect(protect), .adj_q(adj_q), .sw_start(sw_start),
      .halt_q(halt_q), .bank_q(bank_q), .ctrl_word(ctrl_word)
   );

   rtc_adj_timer #(.LOCK_TICKS(LOCK_TICKS), .CLEAR_TICKS(CLEAR_TICKS), .HW_EDGE(HW_EDGE)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hw_req(hw_adj_req),
      .sw_start(sw_start), .adj_q(adj_q), .lock_active(lock_active),
      .adj_strobe(adj_strobe), .flag_set(flag_set)
   );

   rtc_adj_gate #(.AW(AW), .DW(DW)) u_gate (
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .cal_mode(cal_mode),
      .bank_q(bank_q), .lock_active(lock_active), .ctrl_word(ctrl_word),
      .tk_rdata(tk_rdata), .rdata(rdata), .wr_fwd(wr_fwd), .blk_map(blk_map)
   );

   assign ctrl_q     = ctrl_word;
   assign presc_halt = halt_q;
endmodule

// File: rtl/rtc_adj_ctrl_chk.sv
module rtc_adj_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        tick,
   input logic        cal_mode,
   input logic        rd_en,
   input logic [3:0]  addr,
   input logic [3:0]  rdata,
   input logic [15:0] blk_map,
   input logic [3:0]  ctrl_q,
   input logic        flag_set,
   input logic        adj_strobe,
   input logic        presc_halt
);
   a_r7_flag_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_q[0]) |-> flag_set);
   a_r7_flag_needs_adj: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set |-> ctrl_q[0]);
   a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      adj_strobe |=> !adj_strobe);
   a_r8_strobe_in_adj: assert property (@(posedge clk) disable iff (!rst_n)
      adj_strobe |-> ctrl_q[0]);
   a_r5_clear_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_q[0]) |-> $past(tick));
   a_r3_ram_open: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_mode |-> (blk_map[11:6] == 6'd0));
   a_r4_bank1_open: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[2] |-> (blk_map == 16'd0));
   a_r4_fenced_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && blk_map[addr]) |-> (rdata == 4'd0));
   a_r2_fence_needs_adj: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_map != 16'd0) |-> ctrl_q[0]);
   a_r10_halt_follows: assert property (@(posedge clk) disable iff (!rst_n)
      presc_halt == ctrl_q[1]);
endmodule

bind rtc_adj_ctrl rtc_adj_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .cal_mode(cal_mode), .rd_en(rd_en),
   .addr(addr), .rdata(rdata), .blk_map(blk_map), .ctrl_q(ctrl_q),
   .flag_set(flag_set), .adj_strobe(adj_strobe), .presc_halt(presc_halt)
);

// File: tb/sim_rtc_adj_ctrl.sv
module sim_rtc_adj_ctrl;
   logic clk = 1'b0, rst_n = 1'b0;
   logic tick = 0, hw_adj_req = 0, cal_mode = 0, protect = 0, wr_en = 0, rd_en = 0;
   logic [3:0] addr = 0, wdata = 0, tk_rdata = 0;
   logic [3:0] rdata, ctrl_q;
   logic wr_fwd, flag_set, adj_strobe, presc_halt;
   logic [15:0] blk_map;

   int n_run = 0, n_fail = 0;

   // reference state, from the requirements
   logic m_adj = 0, m_stop = 0, m_bank = 0, m_flag = 0, m_strb = 0, m_prev = 0;
   int   m_ticks = 0;

   always #2.5 clk = ~clk;

   rtc_adj_ctrl u0 (.*);

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic exp_fenced(input int a);
      if (!m_adj || m_ticks >= 5 || m_bank) return 1'b0;
      if (a > 12) return 1'b0;
      if (!cal_mode && a >= 6 && a <= 11) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic [3:0] exp_ctrl();
      return {1'b0, m_bank, m_stop, m_adj};
   endfunction

   // one cycle: inputs already set at the falling edge
   task automatic cyc();
      logic [15:0] em;
      logic start, wc;
      #1;
      for (int a = 0; a < 16; a++) em[a] = exp_fenced(a);
      chk("R2/R3 fence map", blk_map, em);
      chk("R4 write forward", {15'd0, wr_fwd},
          {15'd0, wr_en && addr != 4'd13 && !em[addr]});
      if (!rd_en)            chk("R12 idle read", {12'd0, rdata}, 16'd0);
      else if (addr == 4'd13) chk("R12 ctrl read", {12'd0, rdata}, {12'd0, exp_ctrl()});
      else if (em[addr])     chk("R4 fenced read", {12'd0, rdata}, 16'd0);
      else                   chk("R4 open read", {12'd0, rdata}, {12'd0, tk_rdata});
      @(posedge clk);
      wc     = wr_en && addr == 4'd13;
      start  = !m_adj && ((hw_adj_req && !m_prev) || (wc && wdata[0] && !protect));
      m_strb = m_adj && tick && m_ticks == 4;
      m_flag = start;
      if (start) begin m_adj = 1; m_ticks = 0; end
      else if (m_adj && tick) begin
         m_ticks++;
         if (m_ticks == 8) m_adj = 0;
      end
      if (wc) begin
         m_bank = wdata[2];
         if (!protect) m_stop = wdata[1];
      end
      m_prev = hw_adj_req;
      @(negedge clk);
      chk("R1/R5/R9 ctrl bits", {12'd0, ctrl_q}, {12'd0, exp_ctrl()});
      chk("R7 flag pulse", {15'd0, flag_set}, {15'd0, m_flag});
      chk("R8 strobe", {15'd0, adj_strobe}, {15'd0, m_strb});
      chk("R10 halt", {15'd0, presc_halt}, {15'd0, m_stop});
   endtask

   task automatic idle(input int n, input bit ticks);
      for (int i = 0; i < n; i++) begin
         wr_en = 0; rd_en = 1; addr = 4'(i % 16); tk_rdata = 4'(i * 7);
         hw_adj_req = 0; tick = ticks && (i % 3 == 2);
         cyc();
      end
      tick = 0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [3:0] d);
      wr_en = 1; rd_en = 0; addr = a; wdata = d; tick = 0; cyc(); wr_en = 0;
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      @(negedge clk);
      chk("R12 reset ctrl", {12'd0, ctrl_q}, 16'd0);
      chk("R10 reset halt", {15'd0, presc_halt}, 16'd0);
      repeat (2) @(negedge clk);
      rst_n = 1;
      // R1: software adjust, CAL=0, probe fence then clear
      wr(4'hD, 4'h0);            // R1 writing 0 does nothing
      wr(4'hD, 4'h1);
      idle(40, 1'b1);
      // R3: CAL=1 fences the RAM span too
      cal_mode = 1;
      wr(4'hD, 4'h1);
      idle(10, 1'b0);
      wr(4'hD, 4'h1);            // R9 request while busy ignored
      idle(30, 1'b1);
      // R6: hardware edge, held high must not retrigger after clear
      hw_adj_req = 1; tick = 0; cyc();
      for (int i = 0; i < 40; i++) begin
         rd_en = 1; addr = 4'(i % 14); tick = (i % 3 == 0); cyc();
      end
      hw_adj_req = 0; idle(3, 1'b0);
      // R11: protect freezes adj/stop, bank still writable
      protect = 1;
      wr(4'hD, 4'h7);
      idle(4, 1'b1);
      wr(4'hD, 4'h0);
      protect = 0;
      // R10: stop bit
      wr(4'hD, 4'h2); idle(2, 1'b0); wr(4'hD, 4'h0);
      // R4: bank 1 never fenced
      wr(4'hD, 4'h5); idle(20, 1'b1); wr(4'hD, 4'h0); idle(30, 1'b1);
      // constrained random
      for (int i = 0; i < 6000; i++) begin
         logic [31:0] r;
         r = $urandom;
         tick       = (r[2:0] == 3'd0);
         hw_adj_req = (r[9:4] == 6'd0) ? ~hw_adj_req : hw_adj_req;
         wr_en      = (r[12:10] == 3'd0);
         rd_en      = r[13];
         addr       = r[14] ? 4'hD : r[18:15];
         wdata      = r[22:19];
         if (wr_en && addr == 4'hD && r[23]) wdata[2] = 1'b0;
         tk_rdata   = r[27:24];
         if (r[31:28] == 4'd0) cal_mode = ~cal_mode;
         if (r[31:28] == 4'd1) protect = ~protect;
         cyc();
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule